// File: doc/BRIEF.md
# Power Stage Fault Supervisor

This block is the digital supervisor for a two-channel switching power stage built from four half-bridges arranged in pairs. It watches the error inputs (an overcurrent flag for each half-bridge, a shared undervoltage flag and a shared overtemperature error) and a shared overtemperature warning. It drives one output-enable per half-bridge pair: high lets the pair switch, low places it in high impedance. It also drives two active-low status flags that together encode the chip state.

The system-level reset input `holdN` is active low. While it is low, every pair is held in high impedance and any tripped state is cleared. A two-bit mode input selects one of three policies after an error:
- **Automatic recovery.** A countdown runs on rising edges of the PWM input, so the hold-off time scales with the switching frequency.
- **Latching shutdown.** The block stays tripped until the reset input is toggled.
- **Protection disabled.** This policy is for test only; errors never trip the block.

The PWM input is asynchronous to `clk`. It passes through a flop synchroniser and an edge detector before it reaches the cycle counter. Each level of the PWM input must therefore last at least two clock periods.

Top module: `pstage_guard`

## Requirements
- R1: With `holdN` high and the mode not `10`, any active error clears all `outEn` bits and pulls `sdFlag` low on the next clock edge. An active error is any `ocFault` bit, `uvFault` or `otErr`.
- R2: `otWarn` on its own never trips the block: `outEn` stays all ones.
- R3: The status pair `{twFlag, sdFlag}` reads as follows:
  - `00` when tripped while the overtemperature error is present.
  - `01` for an overtemperature warning without a trip.
  - `10` when tripped by overcurrent or undervoltage with no temperature flag.
  - `11` in normal operation.
  - `twFlag` is low whenever `otWarn` or `otErr` is high.
- R4: With mode `01` (latching), a trip persists regardless of PWM edges or removal of the error, until `holdN` goes low.
- R5: Mode `11` behaves exactly as latching mode.
- R6: While `holdN` is low, `sdFlag` is high and all `outEn` bits are low whatever the error inputs, and any trip is cleared. When `holdN` returns high with no error present, `outEn` is all ones in that cycle. If an error is still present, the block trips again one edge later.
- R7: With mode `00` (automatic recovery), the block counts PWM rising edges from the trip. After `AR_CYCLES/2` edges, `sdFlag` returns high within four clocks of the edge while `outEn` stays low.
- R8: In mode `00`, after `AR_CYCLES` edges (default 512) with no error present, `outEn` returns to all ones within four clocks. It stays low after `AR_CYCLES-1` edges.
- R9: In mode `00`, if an error is present when the count reaches `AR_CYCLES`, the block trips again (`sdFlag` low) and the count restarts from zero. A further `AR_CYCLES/2` edges are then needed before `sdFlag` rises.
- R10: With mode `10`, errors are ignored: `outEn` stays all ones and `sdFlag` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous power-on reset, active low |
| holdN | input | 1 | Reset input of the power stage, active low; forces high impedance |
| pwmIn | input | 1 | PWM input used as the recovery timebase (asynchronous) |
| modeSel | input | 2 | Protection policy: 00 auto-recovery, 01 latching, 10 disabled, 11 latching |
| ocFault | input | 4 | Overcurrent flag, one per half-bridge |
| uvFault | input | 1 | Shared gate-supply undervoltage flag |
| otWarn | input | 1 | Junction above the warning threshold (125 °C) |
| otErr | input | 1 | Junction above the error threshold (150 °C) |
| outEn | output | 2 | Per-pair enable; 0 places the pair in high impedance |
| sdFlag | output | 1 | Shutdown status, low while tripped |
| twFlag | output | 1 | Temperature status, low on warning or error |

## Verification
Two events can coincide in automatic-recovery mode: the final PWM edge that completes the countdown, and an error that is still asserted. The block must choose between resuming and re-arming in that one cycle. The bench holds an overcurrent flag high through all `AR_CYCLES` edges. It then checks that the block re-trips instead of enabling the outputs, and that the next recovery takes a full restarted count. A second overlap is the reset input falling while a countdown is part-way through; it is judged by checking that enables and status go straight to their reset values and resume immediately on release.

// File: rtl/pstage_pkg.sv
package pstage_pkg;

  typedef enum logic [1:0] {
    MODE_AUTO  = 2'b00,
    MODE_LATCH = 2'b01,
    MODE_OFF   = 2'b10,
    MODE_SPARE = 2'b11
  } guard_mode_e;

  typedef enum logic [1:0] {
    ST_RUN  = 2'b00,
    ST_TRIP = 2'b01,
    ST_COOL = 2'b10
  } guard_state_e;

  typedef struct packed {
    logic cntClear;
    logic cntRun;
  } cnt_ctl_t;

endpackage

// File: rtl/pstage_timebase.sv
module pstage_timebase
  import pstage_pkg::*;
#(
  parameter int AR_CYCLES   = 512,
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     pwmIn,
  input  cnt_ctl_t ctl,
  output logic     atHalf,
  output logic     atFull
);
  localparam int CW   = $clog2(AR_CYCLES + 1);
  localparam int HALF = AR_CYCLES / 2;

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   pwmPrev;
  logic                   pwmTick;
  logic [CW-1:0]          cnt;

  // first stage samples the asynchronous input, later stages settle it
  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= 1'b0;
          else       syncQ[0] <= pwmIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[s] <= 1'b0;
          else       syncQ[s] <= syncQ[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pwmPrev <= 1'b0;
    else       pwmPrev <= syncQ[SYNC_STAGES-1];
  end

  assign pwmTick = syncQ[SYNC_STAGES-1] & ~pwmPrev;

  // clear has priority so a tick on the terminal edge is dropped
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    cnt <= '0;
    else if (ctl.cntClear)        cnt <= '0;
    else if (ctl.cntRun && pwmTick) cnt <= cnt + 1'b1;
  end

  assign atHalf = (cnt == CW'(HALF));
  assign atFull = (cnt == CW'(AR_CYCLES));

endmodule

// File: rtl/pstage_sequencer.sv
module pstage_sequencer
  import pstage_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        holdN,
  input  guard_mode_e modeEnc,
  input  logic        errAny,
  input  logic        atHalf,
  input  logic        atFull,
  output cnt_ctl_t    ctl,
  output logic        isRun,
  output logic        isTrip
);
  guard_state_e stCur, stNext;
  logic forceRun;

  assign forceRun = !holdN || (modeEnc == MODE_OFF);

  always_comb begin
    stNext = stCur;
    if (forceRun) begin
      stNext = ST_RUN;
    end else begin
      case (stCur)
        ST_RUN:  if (errAny) stNext = ST_TRIP;
        ST_TRIP: if (modeEnc == MODE_AUTO && atHalf) stNext = ST_COOL;
        ST_COOL: if (atFull) stNext = errAny ? ST_TRIP : ST_RUN;
        default: stNext = ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stCur <= ST_RUN;
    else       stCur <= stNext;
  end

  always_comb begin
    ctl.cntClear = forceRun || (stCur == ST_RUN) || (stCur == ST_COOL && atFull);
    ctl.cntRun   = (stCur == ST_COOL) || (stCur == ST_TRIP && modeEnc == MODE_AUTO);
  end

  assign isRun  = (stCur == ST_RUN);
  assign isTrip = (stCur == ST_TRIP);

endmodule

// File: rtl/pstage_guard.sv
module pstage_guard
  import pstage_pkg::*;
#(
  parameter int NUM_PAIRS   = 2,
  parameter int AR_CYCLES   = 512,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   holdN,
  input  logic                   pwmIn,
  input  logic [1:0]             modeSel,
  input  logic [2*NUM_PAIRS-1:0] ocFault,
  input  logic                   uvFault,
  input  logic                   otWarn,
  input  logic                   otErr,
  output logic [NUM_PAIRS-1:0]   outEn,
  output logic                   sdFlag,
  output logic                   twFlag
);
  guard_mode_e modeEnc;
  cnt_ctl_t    ctl;
  logic        errAny, atHalf, atFull, isRun, isTrip;

  assign modeEnc = guard_mode_e'(modeSel);
  assign errAny  = (|ocFault) | uvFault | otErr;

  pstage_timebase #(
    .AR_CYCLES  (AR_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_timebase (
    .clk   (clk),
    .rstN  (rstN),
    .pwmIn (pwmIn),
    .ctl   (ctl),
    .atHalf(atHalf),
    .atFull(atFull)
  );

  pstage_sequencer u_sequencer (
    .clk    (clk),
    .rstN   (rstN),
    .holdN  (holdN),
    .modeEnc(modeEnc),
    .errAny (errAny),
    .atHalf (atHalf),
    .atFull (atFull),
    .ctl    (ctl),
    .isRun  (isRun),
    .isTrip (isTrip)
  );

  genvar p;
  generate
    for (p = 0; p < NUM_PAIRS; p++) begin : g_pair
      assign outEn[p] = holdN & isRun;
    end
  endgenerate

  assign sdFlag = ~(holdN & isTrip);
  assign twFlag = ~(otWarn | otErr);

endmodule

// File: rtl/pstage_guard_chk.sv
module pstage_guard_chk #(
  parameter int NUM_PAIRS = 2
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   holdN,
  input logic [1:0]             modeSel,
  input logic [2*NUM_PAIRS-1:0] ocFault,
  input logic                   uvFault,
  input logic                   otErr,
  input logic [NUM_PAIRS-1:0]   outEn
  ,input logic                  sdFlag
);
  logic errIn;
  assign errIn = (|ocFault) | uvFault | otErr;

  AST_ERR_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    (holdN && modeSel != 2'b10 && errIn) |=> (outEn == '0)); // R1

  AST_WARN_NO_TRIP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(outEn) == '1 && !$past(errIn)) |-> (outEn == '1 || !holdN)); // R2

  AST_LATCH_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(sdFlag) && $past(holdN) && $past(modeSel) == 2'b01) |-> (!sdFlag || !holdN)); // R4

  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !holdN |-> (sdFlag && outEn == '0)); // R6

  AST_OFF_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b10 && $past(modeSel) == 2'b10 && holdN) |-> (outEn == '1 && sdFlag)); // R10

endmodule

bind pstage_guard pstage_guard_chk #(.NUM_PAIRS(NUM_PAIRS)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .holdN  (holdN),
  .modeSel(modeSel),
  .ocFault(ocFault),
  .uvFault(uvFault),
  .otErr  (otErr),
  .outEn  (outEn),
  .sdFlag (sdFlag)
);

// File: tb/test_pstage_guard.sv
`timescale 1ns/1ps
module test_pstage_guard;
  localparam int NP   = 2;
  localparam int N    = 512;
  localparam int HALF = N / 2;

  logic          clk = 1'b0;
  logic          rstN, holdN, pwmIn, uvFault, otWarn, otErr;
  logic [1:0]    modeSel;
  logic [2*NP-1:0] ocFault;
  logic [NP-1:0] outEn;
  logic          sdFlag, twFlag;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  pstage_guard #(.NUM_PAIRS(NP), .AR_CYCLES(N)) i_pstage_guard (
    .clk(clk), .rstN(rstN), .holdN(holdN), .pwmIn(pwmIn), .modeSel(modeSel),
    .ocFault(ocFault), .uvFault(uvFault), .otWarn(otWarn), .otErr(otErr),
    .outEn(outEn), .sdFlag(sdFlag), .twFlag(twFlag)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int st();
    return int'({twFlag, sdFlag});
  endfunction

  task automatic pulses(input int n);
    for (int k = 0; k < n; k++) begin
      pwmIn = 1'b1; tick(4);
      pwmIn = 1'b0; tick(4);
    end
  endtask

  task automatic toggleHold();
    holdN = 1'b0; tick(2);
    holdN = 1'b1; tick(1);
  endtask

  task automatic t_warn();
    otWarn = 1'b1; tick(2);
    chk("R2 warn keeps enables", int'(outEn), 3);
    chk("R3 warn status 01", st(), 1);
    otWarn = 1'b0; tick(1);
    chk("R3 normal status 11", st(), 3);
  endtask

  task automatic t_latch(input logic [1:0] m, input string req);
    modeSel = m;
    ocFault[2] = 1'b1; tick(1);
    chk("R1 oc trips next edge", int'(outEn), 0);
    chk("R3 oc status 10", st(), 2);
    ocFault = '0;
    pulses(N + 8);
    chk({req, " latched enables"}, int'(outEn), 0);
    chk({req, " latched status"}, st(), 2);
    holdN = 1'b0; tick(1);
    chk("R6 hold low sd high", st(), 3);
    chk("R6 hold low hiz", int'(outEn), 0);
    holdN = 1'b1; tick(1);
    chk("R6 release resumes", int'(outEn), 3);
  endtask

  task automatic t_ote_uv();
    modeSel = 2'b01;
    otErr = 1'b1; otWarn = 1'b1; tick(1);
    chk("R3 ote status 00", st(), 0);
    chk("R1 ote trips", int'(outEn), 0);
    otErr = 1'b0; otWarn = 1'b0; toggleHold();
    uvFault = 1'b1; tick(1);
    chk("R3 uv status 10", st(), 2);
    uvFault = 1'b0; toggleHold();
    chk("R6 back to normal", st(), 3);
  endtask

  task automatic t_hold_fault();
    holdN = 1'b0; ocFault[0] = 1'b1; tick(3);
    chk("R6 hold low with fault sd", st(), 3);
    chk("R6 hold low with fault hiz", int'(outEn), 0);
    holdN = 1'b1; tick(1);
    chk("R6 retrip after release", st(), 2);
    ocFault = '0; toggleHold();
  endtask

  task automatic t_disabled();
    modeSel = 2'b10; ocFault[3] = 1'b1; uvFault = 1'b1; tick(3);
    chk("R10 disabled enables", int'(outEn), 3);
    chk("R10 disabled sd", int'(sdFlag), 1);
    ocFault = '0; uvFault = 1'b0; modeSel = 2'b01; tick(1);
  endtask

  task automatic t_autorec();
    modeSel = 2'b00;
    uvFault = 1'b1; tick(1);
    uvFault = 1'b0;
    chk("R1 auto trip", int'(outEn), 0);
    pulses(HALF - 1);
    chk("R7 before half sd low", int'(sdFlag), 0);
    pulses(1);
    chk("R7 half sd high", int'(sdFlag), 1);
    chk("R7 half still hiz", int'(outEn), 0);
    pulses(HALF - 1);
    chk("R8 N-1 still hiz", int'(outEn), 0);
    pulses(1);
    chk("R8 N resumes", int'(outEn), 3);
    chk("R8 N status", st(), 3);
  endtask

  task automatic t_rearm();
    modeSel = 2'b00;
    ocFault[1] = 1'b1; tick(1);
    pulses(N);
    chk("R9 rearm sd low", int'(sdFlag), 0);
    chk("R9 rearm hiz", int'(outEn), 0);
    ocFault = '0;
    pulses(HALF - 1);
    chk("R9 restarted count sd low", int'(sdFlag), 0);
    pulses(1);
    chk("R9 restarted half sd high", int'(sdFlag), 1);
    pulses(HALF);
    chk("R8 resume after rearm", int'(outEn), 3);
  endtask

  task automatic t_ar_hold();
    modeSel = 2'b00;
    otErr = 1'b1; tick(1);
    otErr = 1'b0;
    pulses(10);
    holdN = 1'b0; tick(1);
    chk("R6 hold during countdown", st(), 3);
    chk("R6 hold during countdown hiz", int'(outEn), 0);
    holdN = 1'b1; tick(1);
    chk("R6 resume after countdown hold", int'(outEn), 3);
  endtask

  initial begin
    rstN = 1'b0; holdN = 1'b0; pwmIn = 1'b0; modeSel = 2'b00;
    ocFault = '0; uvFault = 1'b0; otWarn = 1'b0; otErr = 1'b0;
    tick(3);
    rstN = 1'b1; tick(1);
    chk("R6 reset state sd", int'(sdFlag), 1);
    chk("R6 reset state hiz", int'(outEn), 0);
    holdN = 1'b1; tick(1);
    chk("R3 reset normal", st(), 3);
    chk("R6 enabled after release", int'(outEn), 3);
    t_warn();
    t_latch(2'b01, "R4");
    t_latch(2'b11, "R5");
    t_ote_uv();
    t_hold_fault();
    t_disabled();
    t_autorec();
    t_rearm();
    t_ar_hold();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule